// File: doc/BRIEF.md
# Operand-Tracking Compute Unit Manager

This block sits between an issue stage and a multi-cycle or pipelined ALU and accounts for one operation from the moment it is issued until its result has been written back. A single-cycle issue pulse captures the operation fields and raises busy. Each source port then gets its own read request and waits for a matching go pulse, which captures the operand on that cycle only. The block presents the gathered operands to the ALU over a valid/ready pair, accepts the ALU result over a second valid/ready pair, and offers that result to the register file with a write request. Busy drops only after the write go pulse has taken the result.

Several operation fields change which operands are fetched. A zero flag forces the first operand to zero. An immediate-valid flag replaces the second operand with immediate data. A live per-port read mask stops a port from being requested and forces its operand to zero. An invert flag complements the first operand before the ALU sees it. Suppressed ports raise no request, so an operation with every port suppressed goes straight to the ALU.

Top module: `opTrackUnit`

## Requirements
- R1: After reset, busy, every read request, the write request, the ALU input valid and the ALU output ready are all low.
- R2: Busy rises in the cycle after an issue pulse taken while idle. It stays high until the cycle after a write go that meets a raised write request, and it never rises without an issue.
- R3: Opcode, invert, zero, immediate data and immediate-valid are captured in the issue cycle and may change afterwards without effect. An issue pulse while busy is ignored.
- R4: For each port that is not suppressed, its bit of rdReq rises in the cycle after issue, holds until its rdGo bit is seen high, and falls in the cycle after that. A go in the same cycle the request rises is accepted, and srcData is sampled only in the go cycle.
- R5: With zero set, port 0 is not requested and operand 0 is zero. With immediate-valid set, port 1 is not requested and operand 1 equals the immediate data.
- R6: A high rdMask bit, held by the issuer while busy, keeps that port's request low and forces its operand to zero. It takes priority over the immediate on port 1.
- R7: With invert set, operand 0 reaches the ALU bitwise complemented. The complement is applied after zero or mask selection, so that 5 inverted plus 2 gives 65532 at 16 bits.
- R8: aluInValid rises only once every unsuppressed port has been captured, and holds until aluInReady. There is exactly one ALU input transfer per operation, with operand i at aluOperands bits [i*WIDTH +: WIDTH] and the captured opcode on aluOp.
- R9: aluOutReady is high only while busy, after the input transfer, and while no result is held. wrReq rises in the cycle after the ALU output transfer, and wrData holds that result steadily until the write go.
- R10: When handshakes answer within a few cycles, an operation completes in fewer than 50 cycles from issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | One-cycle issue pulse |
| opCode | input | OP_W | Operation code |
| invA | input | 1 | Complement operand 0 |
| zeroA | input | 1 | Force operand 0 to zero, no read |
| immData | input | WIDTH | Immediate value for operand 1 |
| immValid | input | 1 | Use immediate for operand 1, no read |
| rdMask | input | NUM_SRC | Live per-port read suppression |
| busy | output | 1 | Operation in flight |
| rdReq | output | NUM_SRC | Per-port read request |
| rdGo | input | NUM_SRC | Per-port read go pulse |
| srcData | input | NUM_SRC*WIDTH | Operand data, valid in go cycle |
| aluInValid | output | 1 | Operands ready for the ALU |
| aluInReady | input | 1 | ALU accepts operands |
| aluOp | output | OP_W | Captured opcode |
| aluOperands | output | NUM_SRC*WIDTH | Operands to the ALU |
| aluOutValid | input | 1 | ALU result valid |
| aluOutReady | output | 1 | Unit accepts ALU result |
| aluResult | input | WIDTH | ALU result |
| wrReq | output | 1 | Result waiting for writeback |
| wrGo | input | 1 | Write go pulse |
| wrData | output | WIDTH | Held result |

## Verification
The bench builds the unit with three source ports, 16-bit data and a 4-bit opcode. The third port keeps the mask path separate from the zero and immediate paths, and the 16-bit width makes the complemented-operand wraparound visible. A behavioural ALU stand-in with a programmable latency and input stall lets each operation combine go delays of zero and several cycles with stalled or immediate ALU handshakes and late write go pulses. One case issues again while busy, and another masks every port.

// File: rtl/opTrackPkg.sv
package opTrackPkg;
  typedef struct packed {
    logic latchOp;
    logic aluFire;
    logic resFire;
  } ctrlStrobeT;
endpackage

// File: rtl/opTrackCtrl.sv
module opTrackCtrl
  import opTrackPkg::*;
#(
  parameter int NUM_SRC = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               issue,
  input  logic               zeroA,
  input  logic               immValid,
  input  logic [NUM_SRC-1:0] rdMask,
  input  logic [NUM_SRC-1:0] rdGo,
  input  logic               aluInReady,
  input  logic               aluOutValid,
  input  logic               wrGo,
  output logic               busy,
  output logic [NUM_SRC-1:0] rdReq,
  output logic [NUM_SRC-1:0] capture,
  output logic               aluInValid,
  output logic               aluOutReady,
  output logic               wrReq,
  output ctrlStrobeT         strobe
);
  logic               busyQ, sentQ, heldQ;
  logic [NUM_SRC-1:0] needQ, needInit;
  logic               accept, done;

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : gNeed
      if (i == 0) begin : gPortA
        assign needInit[i] = ~zeroA;
      end else if (i == 1) begin : gPortB
        assign needInit[i] = ~immValid;
      end else begin : gPortN
        assign needInit[i] = 1'b1;
      end
    end
  endgenerate

  assign accept      = issue & ~busyQ;
  assign rdReq       = {NUM_SRC{busyQ}} & needQ & ~rdMask;
  assign capture     = rdReq & rdGo;
  assign aluInValid  = busyQ & ~(|rdReq) & ~sentQ;
  assign aluOutReady = busyQ & sentQ & ~heldQ;
  assign wrReq       = heldQ;
  assign done        = heldQ & wrGo;
  assign busy        = busyQ;

  assign strobe.latchOp = accept;
  assign strobe.aluFire = aluInValid & aluInReady;
  assign strobe.resFire = aluOutValid & aluOutReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      sentQ <= 1'b0;
      heldQ <= 1'b0;
      needQ <= '0;
    end else if (accept) begin
      busyQ <= 1'b1;
      sentQ <= 1'b0;
      heldQ <= 1'b0;
      needQ <= needInit;
    end else if (done) begin
      busyQ <= 1'b0;
      sentQ <= 1'b0;
      heldQ <= 1'b0;
      needQ <= '0;
    end else begin
      needQ <= needQ & ~capture;
      if (strobe.aluFire) sentQ <= 1'b1;
      if (strobe.resFire) heldQ <= 1'b1;
    end
  end

  a_r2_no_spontaneous_busy: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !issue) |=> !busy);
  a_r2_busy_until_write: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !(wrGo && wrReq)) |=> busy);
  a_r2_busy_drops_after_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrGo && wrReq) |=> !busy);
  a_r4_req_falls_after_go: assert property (@(posedge clk) disable iff (!rstN)
    ((rdReq & rdGo) != '0) |=> ((rdReq & $past(rdReq & rdGo)) == '0));
  a_r8_valid_held: assert property (@(posedge clk) disable iff (!rstN)
    (aluInValid && !aluInReady) |=> aluInValid);
  a_r9_no_accept_while_held: assert property (@(posedge clk) disable iff (!rstN)
    wrReq |-> !aluOutReady);
  a_r9_wrreq_after_result: assert property (@(posedge clk) disable iff (!rstN)
    (aluOutValid && aluOutReady) |=> wrReq);
endmodule

// File: rtl/opTrackData.sv
module opTrackData
  import opTrackPkg::*;
#(
  parameter int NUM_SRC = 2,
  parameter int WIDTH   = 16,
  parameter int OP_W    = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrobeT               strobe,
  input  logic [NUM_SRC-1:0]       capture,
  input  logic [OP_W-1:0]          opCode,
  input  logic                     invA,
  input  logic                     zeroA,
  input  logic [WIDTH-1:0]         immData,
  input  logic                     immValid,
  input  logic [NUM_SRC-1:0]       rdMask,
  input  logic [NUM_SRC*WIDTH-1:0] srcData,
  input  logic [WIDTH-1:0]         aluResult,
  output logic [OP_W-1:0]          aluOp,
  output logic [NUM_SRC*WIDTH-1:0] aluOperands,
  output logic [WIDTH-1:0]         wrData
);
  localparam int BUS_W = NUM_SRC * WIDTH;

  logic [OP_W-1:0]  opQ;
  logic             invQ, zeroQ, immValidQ;
  logic [WIDTH-1:0] immQ, resQ;
  logic [BUS_W-1:0] srcQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opQ       <= '0;
      invQ      <= 1'b0;
      zeroQ     <= 1'b0;
      immValidQ <= 1'b0;
      immQ      <= '0;
      resQ      <= '0;
    end else begin
      if (strobe.latchOp) begin
        opQ       <= opCode;
        invQ      <= invA;
        zeroQ     <= zeroA;
        immValidQ <= immValid;
        immQ      <= immData;
      end
      if (strobe.resFire) resQ <= aluResult;
    end
  end

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : gPort
      logic [WIDTH-1:0] raw;
      assign raw = srcQ[i*WIDTH +: WIDTH];

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) srcQ[i*WIDTH +: WIDTH] <= '0;
        else if (capture[i]) srcQ[i*WIDTH +: WIDTH] <= srcData[i*WIDTH +: WIDTH];
      end

      if (i == 0) begin : gOpA
        logic [WIDTH-1:0] base;
        assign base = (rdMask[i] | zeroQ) ? '0 : raw;
        assign aluOperands[i*WIDTH +: WIDTH] = base ^ {WIDTH{invQ}};
      end else if (i == 1) begin : gOpB
        assign aluOperands[i*WIDTH +: WIDTH] =
          rdMask[i] ? '0 : (immValidQ ? immQ : raw);
      end else begin : gOpN
        assign aluOperands[i*WIDTH +: WIDTH] = rdMask[i] ? '0 : raw;
      end
    end
  endgenerate

  assign aluOp  = opQ;
  assign wrData = resQ;

  a_r3_op_stable_after_issue: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.latchOp |=> $stable(aluOp));
  a_r4_capture_only_on_go: assert property (@(posedge clk) disable iff (!rstN)
    (capture == '0) |=> $stable(srcQ));
endmodule

// File: rtl/opTrackUnit.sv
module opTrackUnit
  import opTrackPkg::*;
#(
  parameter int NUM_SRC = 2,
  parameter int WIDTH   = 16,
  parameter int OP_W    = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     issue,
  input  logic [OP_W-1:0]          opCode,
  input  logic                     invA,
  input  logic                     zeroA,
  input  logic [WIDTH-1:0]         immData,
  input  logic                     immValid,
  input  logic [NUM_SRC-1:0]       rdMask,
  output logic                     busy,
  output logic [NUM_SRC-1:0]       rdReq,
  input  logic [NUM_SRC-1:0]       rdGo,
  input  logic [NUM_SRC*WIDTH-1:0] srcData,
  output logic                     aluInValid,
  input  logic                     aluInReady,
  output logic [OP_W-1:0]          aluOp,
  output logic [NUM_SRC*WIDTH-1:0] aluOperands,
  input  logic                     aluOutValid,
  output logic                     aluOutReady,
  input  logic [WIDTH-1:0]         aluResult,
  output logic                     wrReq,
  input  logic                     wrGo,
  output logic [WIDTH-1:0]         wrData
);
  ctrlStrobeT         strobe;
  logic [NUM_SRC-1:0] capture;

  opTrackCtrl #(.NUM_SRC(NUM_SRC)) uCtrl (
    .clk(clk), .rstN(rstN), .issue(issue), .zeroA(zeroA), .immValid(immValid),
    .rdMask(rdMask), .rdGo(rdGo), .aluInReady(aluInReady),
    .aluOutValid(aluOutValid), .wrGo(wrGo), .busy(busy), .rdReq(rdReq),
    .capture(capture), .aluInValid(aluInValid), .aluOutReady(aluOutReady),
    .wrReq(wrReq), .strobe(strobe)
  );

  opTrackData #(.NUM_SRC(NUM_SRC), .WIDTH(WIDTH), .OP_W(OP_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .capture(capture),
    .opCode(opCode), .invA(invA), .zeroA(zeroA), .immData(immData),
    .immValid(immValid), .rdMask(rdMask), .srcData(srcData),
    .aluResult(aluResult), .aluOp(aluOp), .aluOperands(aluOperands),
    .wrData(wrData)
  );

  a_r9_result_held: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && !wrGo) |=> (wrReq && $stable(wrData)));
  a_r3_issue_ignored_when_busy: assert property (@(posedge clk) disable iff (!rstN)
    (busy && issue && !wrReq) |=> busy);
endmodule

// File: tb/tb_opTrackUnit.sv
module tb_opTrackUnit;
  localparam int N = 3;
  localparam int W = 16;
  localparam int OW = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic            rstN, issue, invA, zeroA, immValid;
  logic [OW-1:0]   opCode;
  logic [W-1:0]    immData;
  logic [N-1:0]    rdMask, rdGo;
  logic [N*W-1:0]  srcData;
  logic            aluInReady, aluOutValid, wrGo;
  logic [W-1:0]    aluResult;
  logic            busy, aluInValid, aluOutReady, wrReq;
  logic [N-1:0]    rdReq;
  logic [OW-1:0]   aluOp;
  logic [N*W-1:0]  aluOperands;
  logic [W-1:0]    wrData;

  opTrackUnit #(.NUM_SRC(N), .WIDTH(W), .OP_W(OW)) dut (
    .clk(clk), .rstN(rstN), .issue(issue), .opCode(opCode), .invA(invA),
    .zeroA(zeroA), .immData(immData), .immValid(immValid), .rdMask(rdMask),
    .busy(busy), .rdReq(rdReq), .rdGo(rdGo), .srcData(srcData),
    .aluInValid(aluInValid), .aluInReady(aluInReady), .aluOp(aluOp),
    .aluOperands(aluOperands), .aluOutValid(aluOutValid),
    .aluOutReady(aluOutReady), .aluResult(aluResult), .wrReq(wrReq),
    .wrGo(wrGo), .wrData(wrData)
  );

  int total = 0;
  int bad = 0;
  int cycles = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // per-operation stimulus settings
  int          goDly[N];
  int          goWait[N];
  logic [W-1:0] portVal[N];
  int          wrDly, wrWait, stallLeft, aluLat;
  logic [W-1:0] expResult;

  // behavioural reference state
  bit          mBusy, mSent, mHeld;
  bit          mNeed[N];
  logic [W-1:0] mOps[N];
  logic [OW-1:0] mOp;
  bit          mInv, mZero, mImmV;
  logic [W-1:0] mImm;

  // ALU stand-in
  bit          mockPend;
  int          mockCnt;
  logic [W-1:0] mockVal;

  function automatic logic [W-1:0] expOperand(int i);
    logic [W-1:0] v;
    if (i == 0) begin
      v = (rdMask[0] || mZero) ? '0 : mOps[0];
      if (mInv) v = ~v;
    end else if (i == 1) begin
      v = rdMask[1] ? '0 : (mImmV ? mImm : mOps[1]);
    end else begin
      v = rdMask[i] ? '0 : mOps[i];
    end
    return v;
  endfunction

  task automatic step();
    logic [N-1:0] expReq;
    bit expInValid, expOutReady, fire, outFire;
    logic [W-1:0] sum;
    // compare observed outputs with the reference
    for (int i = 0; i < N; i++) expReq[i] = mBusy && mNeed[i] && !rdMask[i];
    expInValid  = mBusy && (expReq == '0) && !mSent;
    expOutReady = mBusy && mSent && !mHeld;
    chk(busy == mBusy, "R2 busy", busy, mBusy);
    chk(rdReq == expReq, "R4/R5/R6 rdReq", rdReq, expReq);
    chk(aluInValid == expInValid, "R8 aluInValid", aluInValid, expInValid);
    chk(aluOutReady == expOutReady, "R9 aluOutReady", aluOutReady, expOutReady);
    chk(wrReq == mHeld, "R9 wrReq", wrReq, mHeld);
    // drive handshake inputs for this cycle
    aluInReady = (stallLeft == 0);
    fire = aluInValid && aluInReady;
    if (aluInValid && !aluInReady) stallLeft--;
    if (fire) begin
      chk(aluOp == mOp, "R3 aluOp", aluOp, mOp);
      for (int i = 0; i < N; i++)
        chk(aluOperands[i*W +: W] == expOperand(i), "R5/R6/R7/R8 operand",
            aluOperands[i*W +: W], expOperand(i));
    end
    rdGo = '0;
    for (int i = 0; i < N; i++) begin
      srcData[i*W +: W] = 16'hBAD0 + W'(i);
      if (rdReq[i]) begin
        if (goWait[i] >= goDly[i]) begin
          rdGo[i] = 1'b1;
          srcData[i*W +: W] = portVal[i];
          goWait[i] = 0;
        end else goWait[i]++;
      end
    end
    wrGo = 1'b0;
    if (wrReq) begin
      if (wrWait >= wrDly) begin
        wrGo = 1'b1;
        wrWait = 0;
        chk(wrData == expResult, "R9 wrData", wrData, expResult);
      end else wrWait++;
    end
    outFire = aluOutValid && aluOutReady;
    // advance the reference
    if (mBusy && mHeld && wrGo) begin
      mBusy = 0; mHeld = 0; mSent = 0;
    end else if (mBusy) begin
      for (int i = 0; i < N; i++)
        if (expReq[i] && rdGo[i]) begin mNeed[i] = 0; mOps[i] = portVal[i]; end
      if (fire) mSent = 1;
      if (expOutReady && aluOutValid) mHeld = 1;
    end else if (issue) begin
      mBusy = 1; mSent = 0; mHeld = 0;
      mOp = opCode; mInv = invA; mZero = zeroA; mImmV = immValid; mImm = immData;
      for (int i = 0; i < N; i++) mNeed[i] = 1;
      if (zeroA) mNeed[0] = 0;
      if (immValid) mNeed[1] = 0;
    end
    // ALU stand-in: the sum of all operands
    if (outFire) mockPend = 0;
    else if (mockPend && mockCnt > 0) mockCnt--;
    if (fire) begin
      sum = '0;
      for (int i = 0; i < N; i++) sum = sum + aluOperands[i*W +: W];
      mockPend = 1; mockCnt = aluLat; mockVal = sum;
    end
    @(posedge clk);
    #1;
    aluOutValid = mockPend && (mockCnt == 0);
    aluResult = mockPend ? mockVal : 16'h5A5A;
    @(negedge clk);
  endtask

  task automatic runOp(input logic [W-1:0] a, b, c, input logic [OW-1:0] op,
                       input bit inv, input logic [W-1:0] imm, input bit immV,
                       input bit zero, input logic [N-1:0] mask,
                       input int d0, d1, d2, wd, st, lt,
                       input logic [W-1:0] expect_v, input bit dbl);
    int n;
    portVal[0] = a; portVal[1] = b; portVal[2] = c;
    goDly[0] = d0; goDly[1] = d1; goDly[2] = d2;
    for (int i = 0; i < N; i++) goWait[i] = 0;
    wrDly = wd; wrWait = 0; stallLeft = st; aluLat = lt; expResult = expect_v;
    rdMask = mask;
    issue = 1; opCode = op; invA = inv; immData = imm; immValid = immV; zeroA = zero;
    step();
    // scramble the fields: the captured copies must be used (R3)
    issue = 0; opCode = ~op; invA = ~inv; immData = ~imm; immValid = ~immV; zeroA = ~zero;
    n = 0;
    while (n < 60) begin
      if (dbl && n == 2) begin issue = 1; opCode = 4'hF; immData = 16'h7777; end
      step();
      issue = 0;
      n++;
      if (!mBusy) break;
    end
    chk(n < 50, "R10 completion bound", n, 50);
    chk(!busy, "R2 busy low after write", busy, 0);
    rdMask = '0;
    step();
  endtask

  initial begin
    rstN = 0; issue = 0; opCode = '0; invA = 0; zeroA = 0; immData = '0; immValid = 0;
    rdMask = '0; rdGo = '0; srcData = '0; aluInReady = 0; aluOutValid = 0; wrGo = 0;
    aluResult = '0;
    mBusy = 0; mSent = 0; mHeld = 0; mockPend = 0; mockCnt = 0; mockVal = '0;
    for (int i = 0; i < N; i++) begin mNeed[i] = 0; mOps[i] = '0; goDly[i] = 0; goWait[i] = 0; portVal[i] = '0; end
    wrDly = 0; wrWait = 0; stallLeft = 0; aluLat = 0; expResult = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 0, "R1 busy", busy, 0);
    chk(rdReq == '0, "R1 rdReq", rdReq, 0);
    chk(wrReq == 0, "R1 wrReq", wrReq, 0);
    chk(aluInValid == 0 && aluOutReady == 0, "R1 alu handshake", {aluInValid, aluOutReady}, 0);
    rstN = 1;
    repeat (4) step();  // idle: busy must not rise on its own (R2)
    // R2 R4 R8: plain sum, staggered gos
    runOp(5, 2, 0, 4'h1, 0, 0, 0, 0, 3'b000, 0, 2, 1, 0, 0, 1, 16'd7, 0);
    // R7 R6: inverted A, port 2 masked, 5 inverted + 2 = 65532
    runOp(5, 2, 9, 4'h2, 1, 0, 0, 0, 3'b100, 1, 2, 0, 2, 1, 2, 16'd65532, 0);
    // R5: zero A and immediate, only port 2 fetched
    runOp(5, 2, 1, 4'h3, 0, 8, 1, 1, 3'b000, 0, 0, 3, 1, 0, 0, 16'd9, 0);
    // R5: immediate only
    runOp(5, 2, 0, 4'h4, 0, 8, 1, 0, 3'b000, 2, 0, 0, 2, 0, 1, 16'd13, 0);
    // R6: all ports masked, mask beats the immediate
    runOp(5, 2, 3, 4'h5, 0, 8, 1, 0, 3'b111, 0, 0, 0, 1, 2, 0, 16'd0, 0);
    // R7: zero then invert gives all ones, 0xFFFF + 3 wraps to 2
    runOp(5, 3, 0, 4'h6, 1, 0, 0, 1, 3'b000, 0, 1, 0, 0, 0, 3, 16'd2, 0);
    // R3: second issue while busy is ignored
    runOp(9, 2, 4, 4'h7, 0, 0, 0, 0, 3'b000, 3, 4, 2, 3, 1, 2, 16'd15, 1);
    // R4: all gos in the cycle the request rises, stalled ALU input
    runOp(3, 4, 5, 4'h8, 0, 0, 0, 0, 3'b000, 0, 0, 0, 0, 2, 0, 16'd12, 0);
    repeat (3) step();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      total++;
      bad++;
      $display("FAIL watchdog expired at cycle %0d", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule